// File: doc/BRIEF.md
# Double-Buffered Swath Memory Arbiter

This block sits in front of a single-port 512 x 16 SRAM that holds image swath data. It treats the SRAM as two 256-word halves. A fetch engine writes incoming swath words into one half. At the same time, a packer engine reads the other half out for bit rotation. When both engines report that they have finished their halves, the halves trade roles. This way the memory only has to be refilled at the rate the output consumes it.

A rotation-enable input chooses between two modes. When rotation is off, the memory belongs to the host bus alone. The host addresses it through a 1 KB byte window that covers all 512 words. When rotation is on, every host access is refused with an error response. The fetch and packer engines then compete for the single memory port. A two-way round-robin arbiter grants at most one of them per cycle. Each engine supplies an 8-bit address inside its own half, and the block adds the bank bit.

The block holds the bank ownership state and the arbiter priority state. It drives the SRAM control signals combinationally from the requests. Read data comes back from the SRAM one cycle after the access and is passed unchanged to both the host and the packer.

Top module: `pingpong_arb`

## Requirements
- R1: After reset, `fetch_bank` is 0, no grant is given and `mem_en` is 0 while no request is present.
- R2: While `rotate_on` is 0, a host request is acknowledged in the same cycle and drives the memory with word address `host_addr[9:1]`, write enable `host_we` and `host_wdata`. Fetch and packer requests receive no grant.
- R3: While `rotate_on` is 1, a host request gets `host_err`=1 and `host_ack`=0, and it never enables the memory.
- R4: A fetch grant is a write (`mem_we`=1) to word address {`fetch_bank`, `fetch_addr`} with data `fetch_wdata`.
- R5: A packer grant is a read (`mem_we`=0) to word address {not `fetch_bank`, `pack_addr`}, so the two engines never use the same half.
- R6: At most one of `fetch_gnt` and `pack_gnt` is 1 in any cycle, and `mem_en` is 1 exactly when some access is granted.
- R7: When only one engine is eligible, that engine is granted. When both are eligible, the engine not granted most recently wins. The first contention after rotation starts goes to the fetch engine.
- R8: From the cycle after `fetch_full` is seen, fetch requests are stalled until the next swap. From the cycle after `pack_empty` is seen, packer requests are stalled until the next swap.
- R9: Once both `fetch_full` and `pack_empty` have been seen (in the same cycle or in different cycles), `fetch_bank` toggles at the next clock edge and both stall conditions clear.
- R10: A cycle with `rotate_on`=0 returns `fetch_bank` to 0 at the next edge. It also clears both stall conditions and restores the fetch-first priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rotate_on | input | 1 | Rotation mode enable; locks out the host |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | 10 | Host byte address in the 1 KB window |
| host_wdata | input | 16 | Host write data |
| host_ack | output | 1 | Host access performed this cycle |
| host_err | output | 1 | Host access refused (rotation active) |
| host_rdata | output | 16 | Read data, valid the cycle after the access |
| fetch_req | input | 1 | Fetch engine write request |
| fetch_addr | input | 8 | Word address inside the fetch half |
| fetch_wdata | input | 16 | Fetch write data |
| fetch_full | input | 1 | Fetch engine has filled its half |
| fetch_gnt | output | 1 | Fetch write performed this cycle |
| pack_req | input | 1 | Packer read request |
| pack_addr | input | 8 | Word address inside the packer half |
| pack_empty | input | 1 | Packer has drained its half |
| pack_gnt | output | 1 | Packer read performed this cycle |
| pack_rdata | output | 16 | Read data, valid the cycle after the grant |
| fetch_bank | output | 1 | Half currently owned by the fetch engine |
| mem_en | output | 1 | SRAM enable |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | 9 | SRAM word address |
| mem_wdata | output | 16 | SRAM write data |
| mem_rdata | input | 16 | SRAM read data |

## Verification
The bench drives `bank-full` and `bank-empty` both in the same cycle and in separate cycles. A design that only swaps on simultaneous pulses would keep the same `fetch_bank`, and one that ignores the remembered pulse would let a finished engine keep writing. Contention sequences check that the winner alternates and that a lone requester is not blocked by stale priority. A wrong arbiter would starve one side or drop a grant. Rotation is turned off partway through a fill with one pulse already recorded. A design that keeps that state would swap too early or stall the fetch engine after restart. Host accesses during lockout are checked at the memory port, where a leak would show up as `mem_en`.

// File: rtl/pp_pkg.sv
package pp_pkg;

    typedef enum logic {
        SRC_FETCH = 1'b0,
        SRC_PACK  = 1'b1
    } src_e;

    typedef struct packed {
        logic fill_bank;
        logic full_seen;
        logic empty_seen;
    } bank_st_t;

    typedef struct packed {
        src_e last;
    } arb_st_t;

endpackage

// File: rtl/pp_bank_ctl.sv
module pp_bank_ctl
    import pp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic fetch_full,
    input  logic pack_empty,
    output logic fill_bank,
    output logic fetch_ok,
    output logic pack_ok
);

    bank_st_t st_d, st_q;
    logic     done_f, done_p;

    always_comb begin
        st_d   = st_q;
        done_f = st_q.full_seen | fetch_full;
        done_p = st_q.empty_seen | pack_empty;
        if (!active) begin
            st_d = '0;
        end else if (done_f && done_p) begin
            st_d.fill_bank  = ~st_q.fill_bank;
            st_d.full_seen  = 1'b0;
            st_d.empty_seen = 1'b0;
        end else begin
            st_d.full_seen  = done_f;
            st_d.empty_seen = done_p;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fill_bank = st_q.fill_bank;
    assign fetch_ok  = active & ~st_q.full_seen;
    assign pack_ok   = active & ~st_q.empty_seen;

    assert_clear_bank0_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (fill_bank == 1'b0) && fetch_ok == pack_ok);

    assert_swap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (active && (fetch_full || !fetch_ok) && (pack_empty || !pack_ok))
        |=> (fill_bank != $past(fill_bank)));

endmodule

// File: rtl/pp_rr_arb.sv
module pp_rr_arb
    import pp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic req_f,
    input  logic req_p,
    output logic gnt_f,
    output logic gnt_p
);

    arb_st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        gnt_f = 1'b0;
        gnt_p = 1'b0;
        if (req_f && req_p) begin
            gnt_f = (st_q.last == SRC_PACK);
            gnt_p = (st_q.last == SRC_FETCH);
        end else begin
            gnt_f = req_f;
            gnt_p = req_p;
        end
        if (gnt_f) st_d.last = SRC_FETCH;
        if (gnt_p) st_d.last = SRC_PACK;
        if (clr)   st_d.last = SRC_PACK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{last: SRC_PACK};
        else        st_q <= st_d;
    end

    assert_one_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(gnt_f && gnt_p));

    assert_sole_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_f != req_p) |-> (gnt_f == req_f) && (gnt_p == req_p));

    assert_alternate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_f && req_p && !clr) |=> (!(req_f && req_p) || (gnt_f != $past(gnt_f))));

endmodule

// File: rtl/pingpong_arb.sv
module pingpong_arb
    import pp_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int BANK_AW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rotate_on,
    input  logic                 host_req,
    input  logic                 host_we,
    input  logic [BANK_AW+1:0]   host_addr,
    input  logic [DATA_W-1:0]    host_wdata,
    output logic                 host_ack,
    output logic                 host_err,
    output logic [DATA_W-1:0]    host_rdata,
    input  logic                 fetch_req,
    input  logic [BANK_AW-1:0]   fetch_addr,
    input  logic [DATA_W-1:0]    fetch_wdata,
    input  logic                 fetch_full,
    output logic                 fetch_gnt,
    input  logic                 pack_req,
    input  logic [BANK_AW-1:0]   pack_addr,
    input  logic                 pack_empty,
    output logic                 pack_gnt,
    output logic [DATA_W-1:0]    pack_rdata,
    output logic                 fetch_bank,
    output logic                 mem_en,
    output logic                 mem_we,
    output logic [BANK_AW:0]     mem_addr,
    output logic [DATA_W-1:0]    mem_wdata,
    input  logic [DATA_W-1:0]    mem_rdata
);

    localparam int MEM_AW = BANK_AW + 1;

    logic fill_bank, fetch_ok, pack_ok, host_go;
    logic unused_byte_lsb;

    assign unused_byte_lsb = host_addr[0];

    pp_bank_ctl i_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (rotate_on),
        .fetch_full (fetch_full),
        .pack_empty (pack_empty),
        .fill_bank  (fill_bank),
        .fetch_ok   (fetch_ok),
        .pack_ok    (pack_ok)
    );

    pp_rr_arb i_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (~rotate_on),
        .req_f (fetch_req & fetch_ok),
        .req_p (pack_req & pack_ok),
        .gnt_f (fetch_gnt),
        .gnt_p (pack_gnt)
    );

    always_comb begin
        host_go   = host_req & ~rotate_on;
        host_ack  = host_go;
        host_err  = host_req & rotate_on;
        mem_en    = host_go | fetch_gnt | pack_gnt;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        if (host_go) begin
            mem_we    = host_we;
            mem_addr  = host_addr[MEM_AW:1];
            mem_wdata = host_wdata;
        end else if (fetch_gnt) begin
            mem_we    = 1'b1;
            mem_addr  = {fill_bank, fetch_addr};
            mem_wdata = fetch_wdata;
        end else if (pack_gnt) begin
            mem_addr  = {~fill_bank, pack_addr};
        end
    end

    assign fetch_bank = fill_bank;
    assign host_rdata = mem_rdata;
    assign pack_rdata = mem_rdata;

    assert_host_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && rotate_on) |-> (host_err && !host_ack));

    assert_host_own_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !rotate_on) |-> (host_ack && mem_en && !fetch_gnt && !pack_gnt));

    assert_fetch_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_gnt |-> (mem_we && mem_addr[MEM_AW-1] == fetch_bank));

    assert_pack_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pack_gnt |-> (!mem_we && mem_addr[MEM_AW-1] != fetch_bank));

    assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rotate_on && fetch_full && !(pack_empty || !pack_ok)) |=> (!fetch_gnt || !rotate_on || $changed(fetch_bank)));

endmodule

// File: tb/test_pingpong_arb.sv
module test_pingpong_arb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rotate_on = 1'b0, host_req = 1'b0, host_we = 1'b0;
    logic [9:0]  host_addr = 10'h2A6;
    logic [15:0] host_wdata = 16'hA5A5;
    logic        host_ack, host_err;
    logic [15:0] host_rdata;
    logic        fetch_req = 1'b0, fetch_full = 1'b0, fetch_gnt;
    logic [7:0]  fetch_addr = 8'h11;
    logic [15:0] fetch_wdata = 16'h3C3C;
    logic        pack_req = 1'b0, pack_empty = 1'b0, pack_gnt;
    logic [7:0]  pack_addr = 8'h22;
    logic [15:0] pack_rdata;
    logic        fetch_bank, mem_en, mem_we;
    logic [8:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = 16'h5AA5;

    int errors = 0, checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pingpong_arb i_pingpong_arb (.*);

    // {rotate_on,host_req,host_we,fetch_req,pack_req,fetch_full,pack_empty}_{fetch_gnt,pack_gnt,host_ack,host_err,fetch_bank}
    localparam logic [11:0] VEC [21] = '{
        12'b0110000_00100, 12'b0101100_00100, 12'b1101100_10010, 12'b1001100_01000,
        12'b1001100_10000, 12'b1000100_01000, 12'b1000100_01000, 12'b1001100_10000,
        12'b1001110_01000, 12'b1001100_01000, 12'b1001000_00000, 12'b1001001_00000,
        12'b1001100_10001, 12'b1001100_01001, 12'b1000011_00001, 12'b1000000_00000,
        12'b1001110_10000, 12'b0000000_00000, 12'b1001101_10000, 12'b1001000_10000,
        12'b1000100_00000
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        {rotate_on, host_req, host_we, fetch_req, pack_req, fetch_full, pack_empty} = '0;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({fetch_bank, fetch_gnt, pack_gnt, mem_en} == 4'b0, "R1 reset", {fetch_bank, fetch_gnt, pack_gnt, mem_en}, 0);
        rst_n = 1'b1;

        for (int i = 0; i < 21; i++) begin
            logic [4:0] e;
            logic       ehack, efg, epg, efb, ewe;
            logic [8:0] eaddr;
            @(negedge clk);
            {rotate_on, host_req, host_we, fetch_req, pack_req, fetch_full, pack_empty} = VEC[i][11:5];
            e = VEC[i][4:0];
            #1;
            // R2 R3 R7 R8 R9 R10: grants, host response and bank
            chk({fetch_gnt, pack_gnt, host_ack, host_err, fetch_bank} == e, $sformatf("R7/R8/R9/R10 vec %0d", i),
                {fetch_gnt, pack_gnt, host_ack, host_err, fetch_bank}, e);
            {efg, epg, ehack, efb} = {e[4], e[3], e[2], e[0]};
            // R6: mem_en iff granted access
            chk(mem_en == (efg | epg | ehack), $sformatf("R6 mem_en vec %0d", i), mem_en, efg | epg | ehack);
            if (efg | epg | ehack) begin
                eaddr = ehack ? host_addr[9:1] : efg ? {efb, fetch_addr} : {~efb, pack_addr};
                ewe   = ehack ? host_we : efg;
                // R2 R4 R5: address and direction
                chk({mem_we, mem_addr} == {ewe, eaddr}, $sformatf("R2/R4/R5 mem vec %0d", i),
                    {mem_we, mem_addr}, {ewe, eaddr});
            end
        end

        // R2: host write data
        @(negedge clk); idle(); host_req = 1'b1; host_we = 1'b1; #1;
        chk(mem_wdata == host_wdata && mem_we, "R2 host wdata", mem_wdata, host_wdata);
        // R4: fetch write data
        @(negedge clk); idle(); rotate_on = 1'b1; fetch_req = 1'b1; #1;
        chk(mem_wdata == fetch_wdata && fetch_gnt, "R4 fetch wdata", mem_wdata, fetch_wdata);
        // R3: refused host access leaves memory idle
        @(negedge clk); idle(); rotate_on = 1'b1; host_req = 1'b1; #1;
        chk({mem_en, host_err, host_ack} == 3'b010, "R3 lockout", {mem_en, host_err, host_ack}, 3'b010);
        // R9 then R1: swap, then reset returns bank 0
        @(negedge clk); idle(); rotate_on = 1'b1; fetch_full = 1'b1; pack_empty = 1'b1;
        @(negedge clk); idle(); rotate_on = 1'b1; #1;
        chk(fetch_bank == 1'b1, "R9 swap", fetch_bank, 1);
        rst_n = 1'b0; #1;
        chk(fetch_bank == 1'b0 && !mem_en, "R1 reset mid-run", fetch_bank, 0);
        @(negedge clk); rst_n = 1'b1; idle();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule